// File: doc/BRIEF.md
# Sharer Directory for an Inclusive L2 Bank

This block sits next to one bank of a shared, inclusive L2 cache. For each line that the bank holds, it keeps a small bit vector that marks which of the attached cores have a copy of the line in their L1 caches. The L1 caches are write-through, so L2 always holds current data. Coherence therefore needs no data forwarding and no writeback requests. Removing stale L1 copies is the only work. Lines are found by an associative compare on the line tag across all directory entries.

A single request channel carries three kinds of events: a core's load fill, a core's store, and an L2 eviction of a line.
- A load fill records the requester as a sharer. If the line has no entry yet, the load first claims a free entry.
- A store sends one invalidation message to every other sharer and clears their bits in the same step. The storing core does not allocate in its L1, so it never becomes a sharer through a store.
- An eviction invalidates all sharers and releases the entry, which keeps L1 contents a subset of L2.

Invalidation messages leave the block as a target-core bit vector plus the line tag, one message per request, under a valid/ready handshake. While a message is waiting, the block takes no new request.

Top module: `sdir_directory`

## Requirements
- R1: After reset `inv_valid` is low, `req_ready` is high and no line is tracked: a store or eviction to any tag produces no message.
- R2: A load (`req_op` 2'b00) whose tag matches no valid entry, when an entry is free, claims an entry for that tag with only the requester (`req_core`, bit `req_core` of the target vector) marked as sharer.
- R3: A load whose tag matches an entry adds the requester to that entry's sharers. Repeating a load from an existing sharer changes nothing.
- R4: A store (`req_op` 2'b01) that matches an entry produces one message whose targets are the entry's sharers without the storing core. Those sharers are cleared in the same step, so an immediate repeat of the store sends nothing.
- R5: A store that misses, or that finds no sharer other than the storer, sends no message and claims no entry.
- R6: An eviction (`req_op` 2'b10) that matches an entry sends one message targeting all of its sharers (none if it has no sharers) and frees the entry. Later stores to that tag send nothing.
- R7: An entry whose sharer set has become empty stays valid: it still occupies its slot, and a later load to its tag hits it.
- R8: A load that misses while all entries are valid is dropped. A later store or eviction of that tag sends nothing.
- R9: A pending message keeps `inv_targets` and `inv_tag` stable until `inv_ready` is high. `req_ready` is low while a message is pending. A message never has an empty target vector, and it appears only in the cycle after an accepted request.
- R10: `inv_tag` equals the tag of the request that caused the message.
- R11: The op code 2'b11 is reserved. It has no effect on any entry and sends no message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_op | input | 2 | 00 load fill, 01 store, 10 L2 eviction, 11 reserved |
| req_core | input | CORE_W (3) | Requesting core index |
| req_tag | input | TAG_W (12) | Line tag |
| inv_valid | output | 1 | Invalidation message pending |
| inv_ready | input | 1 | Consumer takes the message |
| inv_targets | output | NUM_CORES (8) | One bit per core to invalidate |
| inv_tag | output | TAG_W (12) | Tag of the line to invalidate |

## Verification
The bench drives the block with several kinds of request stream, and each kind separates a different class of fault.
- Loads from several cores to one line, followed by a store from a sharer, expose a wrong merge or a wrong exclusion of the storer.
- A store from a core that is not a sharer then clears the whole vector, which shows whether an entry left with no sharers survives.
- Filling every entry and then sending a further load, a store miss and a reserved op separates dropping and ignoring from silent allocation. Each of these is followed by an eviction that reveals what the table holds.
- A burst of evictions under an irregular `inv_ready` pattern tests the holding of messages and the blocking of requests.

// File: rtl/sdir_pkg.sv
package sdir_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_EVICT = 2'b10,
    OP_RSVD  = 2'b11
  } dir_op_e;
endpackage

// File: rtl/sdir_entry.sv
module sdir_entry #(
  parameter int NUM_CORES = 8,
  parameter int TAG_W     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_en,
  input  logic                 add_en,
  input  logic                 keep_en,
  input  logic                 free_en,
  input  logic [TAG_W-1:0]     new_tag,
  input  logic [NUM_CORES-1:0] core_bit,
  output logic                 ent_valid,
  output logic [TAG_W-1:0]     ent_tag,
  output logic [NUM_CORES-1:0] ent_sharers
);
  logic                 valid_d;
  logic [TAG_W-1:0]     tag_d;
  logic [NUM_CORES-1:0] sharers_d;
  logic                 ent_we;

  assign ent_we = alloc_en | add_en | keep_en | free_en;

  always_comb begin
    valid_d   = ent_valid;
    tag_d     = ent_tag;
    sharers_d = ent_sharers;
    if (alloc_en) begin
      valid_d   = 1'b1;
      tag_d     = new_tag;
      sharers_d = core_bit;
    end else if (add_en) begin
      sharers_d = ent_sharers | core_bit;
    end else if (keep_en) begin
      sharers_d = ent_sharers & core_bit;
    end else if (free_en) begin
      valid_d   = 1'b0;
      sharers_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid   <= 1'b0;
      ent_tag     <= '0;
      ent_sharers <= '0;
    end else if (ent_we) begin
      ent_valid   <= valid_d;
      ent_tag     <= tag_d;
      ent_sharers <= sharers_d;
    end
  end
endmodule

// File: rtl/sdir_match.sv
module sdir_match #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 12
) (
  input  logic [ENTRIES-1:0]            valid_vec,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tag_vec,
  input  logic [TAG_W-1:0]              look_tag,
  output logic [ENTRIES-1:0]            hit_vec,
  output logic                          any_hit,
  output logic [ENTRIES-1:0]            free_vec,
  output logic                          all_full
);
  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_cmp
      assign hit_vec[gi] = valid_vec[gi] && (tag_vec[gi] == look_tag);
    end
  endgenerate

  assign any_hit  = |hit_vec;
  assign all_full = &valid_vec;

  always_comb begin
    logic found;
    found    = 1'b0;
    free_vec = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_vec[i] && !found) begin
        free_vec[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdir_inv_port.sv
module sdir_inv_port #(
  parameter int NUM_CORES = 8,
  parameter int TAG_W     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic [NUM_CORES-1:0] load_targets,
  input  logic [TAG_W-1:0]     load_tag,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [NUM_CORES-1:0] out_targets,
  output logic [TAG_W-1:0]     out_tag
);
  logic valid_d;
  logic data_we;

  assign data_we = load_en;

  always_comb begin
    valid_d = out_valid;
    if (load_en)
      valid_d = 1'b1;
    else if (out_valid && out_ready)
      valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_targets <= '0;
      out_tag     <= '0;
    end else if (data_we) begin
      out_targets <= load_targets;
      out_tag     <= load_tag;
    end
  end
endmodule

// File: rtl/sdir_directory.sv
module sdir_directory #(
  parameter int NUM_CORES = 8,
  parameter int ENTRIES   = 8,
  parameter int TAG_W     = 12,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_op,
  input  logic [CORE_W-1:0]    req_core,
  input  logic [TAG_W-1:0]     req_tag,
  output logic                 inv_valid,
  input  logic                 inv_ready,
  output logic [NUM_CORES-1:0] inv_targets,
  output logic [TAG_W-1:0]     inv_tag
);
  import sdir_pkg::*;

  logic                          accept;
  logic                          is_load, is_store, is_evict;
  logic [NUM_CORES-1:0]          core_bit;
  logic [ENTRIES-1:0]            valid_vec;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_vec;
  logic [ENTRIES-1:0][NUM_CORES-1:0] sharer_vec;
  logic [ENTRIES-1:0]            hit_vec;
  logic [ENTRIES-1:0]            free_vec;
  logic                          any_hit;
  logic                          all_full;
  logic                          do_alloc;
  logic [NUM_CORES-1:0]          hit_sharers;
  logic [NUM_CORES-1:0]          send_targets;
  logic                          send_en;

  assign req_ready = !inv_valid;
  assign accept    = req_valid && req_ready;
  assign is_load   = (dir_op_e'(req_op) == OP_LOAD);
  assign is_store  = (dir_op_e'(req_op) == OP_STORE);
  assign is_evict  = (dir_op_e'(req_op) == OP_EVICT);
  assign core_bit  = NUM_CORES'(1) << req_core;
  assign do_alloc  = accept && is_load && !any_hit && !all_full;

  sdir_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
    .valid_vec (valid_vec),
    .tag_vec   (tag_vec),
    .look_tag  (req_tag),
    .hit_vec   (hit_vec),
    .any_hit   (any_hit),
    .free_vec  (free_vec),
    .all_full  (all_full)
  );

  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_ent
      sdir_entry #(.NUM_CORES(NUM_CORES), .TAG_W(TAG_W)) u_entry (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_en    (do_alloc && free_vec[gi]),
        .add_en      (accept && is_load && hit_vec[gi]),
        .keep_en     (accept && is_store && hit_vec[gi]),
        .free_en     (accept && is_evict && hit_vec[gi]),
        .new_tag     (req_tag),
        .core_bit    (core_bit),
        .ent_valid   (valid_vec[gi]),
        .ent_tag     (tag_vec[gi]),
        .ent_sharers (sharer_vec[gi])
      );
    end
  endgenerate

  always_comb begin
    hit_sharers = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i])
        hit_sharers = hit_sharers | sharer_vec[i];
    end
  end

  always_comb begin
    send_targets = '0;
    if (is_store)
      send_targets = hit_sharers & ~core_bit;
    else if (is_evict)
      send_targets = hit_sharers;
  end

  assign send_en = accept && any_hit && (send_targets != '0);

  sdir_inv_port #(.NUM_CORES(NUM_CORES), .TAG_W(TAG_W)) u_inv (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_en      (send_en),
    .load_targets (send_targets),
    .load_tag     (req_tag),
    .out_ready    (inv_ready),
    .out_valid    (inv_valid),
    .out_targets  (inv_targets),
    .out_tag      (inv_tag)
  );
endmodule

// File: rtl/sdir_checker.sv
module sdir_checker #(
  parameter int NUM_CORES = 8,
  parameter int ENTRIES   = 8,
  parameter int TAG_W     = 12,
  parameter int CORE_W    = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [1:0]           req_op,
  input logic [CORE_W-1:0]    req_core,
  input logic [TAG_W-1:0]     req_tag,
  input logic                 inv_valid,
  input logic                 inv_ready,
  input logic [NUM_CORES-1:0] inv_targets,
  input logic [TAG_W-1:0]     inv_tag,
  input logic [ENTRIES-1:0]   hit_vec
);
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_targets) && $stable(inv_tag));

  // R9
  nonempty_targets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> inv_targets != '0);

  // R9
  msg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_valid) |-> $past(req_valid && req_ready));

  // R4
  storer_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_op == 2'b01 |=> !(inv_valid && inv_targets[$past(req_core)]));

  // R10
  msg_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !inv_valid || inv_tag == $past(req_tag));

  // R11
  reserved_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_op == 2'b11 |=> !inv_valid);

  // R7
  unique_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

bind sdir_directory sdir_checker #(
  .NUM_CORES (NUM_CORES),
  .ENTRIES   (ENTRIES),
  .TAG_W     (TAG_W),
  .CORE_W    (CORE_W)
) u_chk (.*);

// File: tb/sdir_directory_test.sv
module sdir_directory_test;
  localparam int NC = 8;
  localparam int NE = 8;
  localparam int TW = 12;
  localparam int CW = 3;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_op;
  logic [CW-1:0] req_core;
  logic [TW-1:0] req_tag;
  logic          inv_valid;
  logic          inv_ready;
  logic [NC-1:0] inv_targets;
  logic [TW-1:0] inv_tag;

  sdir_directory #(.NUM_CORES(NC), .ENTRIES(NE), .TAG_W(TW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_core(req_core), .req_tag(req_tag),
    .inv_valid(inv_valid), .inv_ready(inv_ready),
    .inv_targets(inv_targets), .inv_tag(inv_tag)
  );

  typedef struct {
    logic [NC-1:0] targets;
    logic [TW-1:0] tag;
    string         rq;
  } exp_t;

  exp_t exp_q[$];
  int   vectors;
  int   misses;
  int   cyc;

  logic          m_valid [NE];
  logic [TW-1:0] m_tag   [NE];
  logic [NC-1:0] m_sh    [NE];

  logic          hold_pend;
  logic [NC-1:0] hold_t;
  logic [TW-1:0] hold_g;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc       <= cyc + 1;
    inv_ready <= ((cyc % 5) != 1) && ((cyc % 7) != 3);
  end

  task automatic report_fail(input string rq, input string what, input int act, input int expv);
    misses++;
    $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, expv);
  endtask

  // Monitor: pops expected messages as the design delivers them
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        vectors++;
        if (!inv_valid || inv_targets != hold_t || inv_tag != hold_g)
          report_fail("R9", "held message changed", {inv_valid, inv_targets}, {1'b1, hold_t});
        hold_pend = 1'b0;
      end
      if (inv_valid) begin
        vectors++;
        if (req_ready) report_fail("R9", "req_ready while pending", 1, 0);
      end
      if (inv_valid && !inv_ready) begin
        hold_pend = 1'b1;
        hold_t    = inv_targets;
        hold_g    = inv_tag;
      end
      if (inv_valid && inv_ready) begin
        vectors++;
        if (exp_q.size() == 0) begin
          report_fail("R5/R11", "unexpected message targets", inv_targets, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (inv_targets != e.targets)
            report_fail(e.rq, "targets", inv_targets, e.targets);
          if (inv_tag != e.tag)
            report_fail("R10", "tag", inv_tag, e.tag);
        end
      end
    end
  end

  task automatic send(input logic [1:0] op, input int core, input logic [TW-1:0] tag, input string rq);
    int h;
    int f;
    logic [NC-1:0] b;
    logic [NC-1:0] t;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    b = NC'(1) << core;
    h = -1;
    f = -1;
    for (int i = 0; i < NE; i++) begin
      if (m_valid[i] && m_tag[i] == tag) h = i;
      if (!m_valid[i] && f < 0) f = i;
    end
    case (op)
      2'b00: begin
        if (h >= 0) m_sh[h] |= b;
        else if (f >= 0) begin
          m_valid[f] = 1'b1; m_tag[f] = tag; m_sh[f] = b;
        end
      end
      2'b01: if (h >= 0) begin
        t = m_sh[h] & ~b;
        if (t != '0) exp_q.push_back('{t, tag, rq});
        m_sh[h] &= b;
      end
      2'b10: if (h >= 0) begin
        if (m_sh[h] != '0) exp_q.push_back('{m_sh[h], tag, rq});
        m_valid[h] = 1'b0;
        m_sh[h]    = '0;
      end
      default: ;
    endcase
    req_valid = 1'b1;
    req_op    = op;
    req_core  = CW'(core);
    req_tag   = tag;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain(input string rq);
    repeat (10) @(negedge clk);
    vectors++;
    if (exp_q.size() != 0)
      report_fail(rq, "expected messages missing", exp_q.size(), 0);
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 20000; wd++) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    vectors   = 0;
    misses    = 0;
    cyc       = 0;
    hold_pend = 1'b0;
    inv_ready = 1'b1;
    req_valid = 1'b0;
    req_op    = 2'b00;
    req_core  = '0;
    req_tag   = '0;
    for (int i = 0; i < NE; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = '0; m_sh[i] = '0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    vectors++;
    if (inv_valid !== 1'b0) report_fail("R1", "inv_valid", inv_valid, 0);
    vectors++;
    if (req_ready !== 1'b1) report_fail("R1", "req_ready", req_ready, 1);
    rst_n = 1'b1;
    send(2'b01, 1, 12'h010, "R1");
    send(2'b10, 1, 12'h010, "R1");
    drain("R1");

    // R2 R3 R4 R5 R6 R10: sharing, store exclusion, eviction
    send(2'b00, 2, 12'h010, "R2");
    send(2'b00, 5, 12'h010, "R3");
    send(2'b00, 5, 12'h010, "R3");
    send(2'b01, 2, 12'h010, "R4");
    send(2'b01, 2, 12'h010, "R5");
    send(2'b00, 6, 12'h010, "R3");
    send(2'b10, 0, 12'h010, "R6");
    send(2'b01, 1, 12'h010, "R6");
    drain("R6");

    // R7 R8: zero-sharer entry kept, full table drops loads
    send(2'b00, 0, 12'h020, "R2");
    send(2'b00, 1, 12'h020, "R3");
    send(2'b00, 7, 12'h020, "R3");
    send(2'b01, 3, 12'h020, "R4");
    for (int k = 1; k < NE; k++) send(2'b00, 4, TW'(12'h020 + k), "R2");
    send(2'b00, 6, 12'h030, "R8");
    send(2'b01, 5, 12'h030, "R8");
    send(2'b10, 6, 12'h030, "R8");
    send(2'b00, 2, 12'h020, "R7");
    send(2'b10, 0, 12'h020, "R7");
    drain("R7");

    // R5: store miss claims nothing, so a later load still finds a slot
    send(2'b01, 1, 12'h031, "R5");
    send(2'b00, 1, 12'h031, "R5");
    send(2'b10, 0, 12'h031, "R5");
    // R11: reserved op leaves the entry untouched
    send(2'b11, 0, 12'h021, "R11");
    send(2'b11, 3, 12'h022, "R11");
    send(2'b10, 0, 12'h021, "R11");
    drain("R11");

    // R9: burst of evictions under irregular inv_ready
    send(2'b00, 7, 12'h023, "R3");
    for (int k = 2; k < NE; k++) send(2'b10, 0, TW'(12'h020 + k), "R9");
    drain("R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule